// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

This block holds two banks of four stored bits. The two banks share their control inputs: a two-bit address, an active-low enable and an active-low clear. Each bank has one data input of its own. The enable and clear levels together select one of four operating modes. In the clear mode every stored bit goes low. In the demultiplex mode the addressed bit of each bank follows that bank's data input and the other bits are driven low. In the write mode only the addressed bit follows the data input and the other bits keep their values. In the hold mode nothing changes.

The block is level-sensitive and is built from one transparent latch per stored bit. Each latch has its own gate, which comes from the mode and the one-hot address decode. For test, a parameter can swap these latches for edge-triggered flops that take the same gate and data. The intended use is to fill the bits one at a time, serial to parallel. The integrator parks the block in hold mode, sets the address there, then opens write mode and later closes it again.

The decode treats the mode as a small set of named states, selected by the level pair {enable_n, clear_n}:
- MODE_DEMUX = 00
- MODE_WRITE = 01
- MODE_CLEAR = 10
- MODE_HOLD = 11

Every transition between any two of these states is allowed. Each transition takes effect as soon as the input levels change. The value present on a bit at the moment the block enters MODE_HOLD is the value it keeps.

Top module: `dual_addr_latch`

## Requirements
- R1: With enable_n high and clear_n low (MODE_CLEAR), all eight outputs are 0. This is also the reset state the bench establishes.
- R2: With enable_n and clear_n both low (MODE_DEMUX), the addressed output of each bank equals that bank's data input.
- R3: In MODE_DEMUX, the three unaddressed outputs of each bank are 0.
- R4: With enable_n low and clear_n high (MODE_WRITE), the addressed output of each bank equals that bank's data input.
- R5: In MODE_WRITE, the three unaddressed outputs of each bank keep their previous values.
- R6: With enable_n and clear_n both high (MODE_HOLD), the outputs do not change when the data or the address changes.
- R7: On entry into MODE_HOLD from MODE_DEMUX or MODE_WRITE, the outputs keep the values they had just before the transition.
- R8: The address selects output index addr[1]*2 + addr[0], and the same index applies in both banks. Bank 0 drives q_o[3:0] and bank 1 drives q_o[7:4]. Bit i of a bank is q_o[bank*4 + i].
- R9: Data input d_i[0] affects only bank 0 and d_i[1] affects only bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the flop variant and for the assertion sampling |
| rst_ni | input | 1 | Active-low reset of the flop variant and of the assertion qualifier |
| en_n_i | input | 1 | Common enable, active low |
| clr_n_i | input | 1 | Common conditional clear, active low |
| addr_i | input | 2 | Common bit address, addr_i[0] least significant |
| d_i | input | 2 | Data input, one bit per bank |
| q_o | output | 8 | Stored outputs, bank 0 in [3:0], bank 1 in [7:4] |

## Verification
In a single step the bench can change the mode and the data at once. It can also enter MODE_HOLD while the data seen in the previous mode is still present. This lets a mode transition and a data write fall into the same instant. The bench provokes this by applying every ordered pair of modes, with every address and every pair of data values. At each pair it also toggles one bank's data. Each step's outputs are compared bit by bit with a bench model that applies the mode rules to the levels present. The address is changed only in MODE_HOLD.

// File: rtl/dal_pkg.sv
package dal_pkg;
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;
endpackage

// File: rtl/dal_mode_dec.sv
module dal_mode_dec
    import dal_pkg::*;
(
    input  logic  en_n_i,
    input  logic  clr_n_i,
    output mode_e mode_o
);
    always_comb begin
        unique case ({en_n_i, clr_n_i})
            2'b00:   mode_o = MODE_DEMUX;
            2'b01:   mode_o = MODE_WRITE;
            2'b10:   mode_o = MODE_CLEAR;
            default: mode_o = MODE_HOLD;
        endcase
    end
endmodule

// File: rtl/dal_addr_dec.sv
module dal_addr_dec #(
    parameter int ADDR_W = 2,
    localparam int BITS  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BITS-1:0]   sel_o
);
    always_comb begin
        for (int i = 0; i < BITS; i++) begin
            sel_o[i] = (addr_i == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/dal_bank.sv
module dal_bank
    import dal_pkg::*;
#(
    parameter int BITS       = 4,
    parameter bit REGISTERED = 1'b0
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  mode_e           mode_i,
    input  logic [BITS-1:0] sel_i,
    input  logic            d_i,
    output logic [BITS-1:0] q_o
);
    logic [BITS-1:0] gate;
    logic [BITS-1:0] next;
    logic [BITS-1:0] store;

    always_comb begin
        for (int i = 0; i < BITS; i++) begin
            unique case (mode_i)
                MODE_CLEAR: begin gate[i] = 1'b1;     next[i] = 1'b0;            end
                MODE_DEMUX: begin gate[i] = 1'b1;     next[i] = sel_i[i] & d_i;  end
                MODE_WRITE: begin gate[i] = sel_i[i]; next[i] = d_i;             end
                default:    begin gate[i] = 1'b0;     next[i] = 1'b0;            end
            endcase
        end
    end

    generate
        if (REGISTERED) begin : g_flop
            for (genvar i = 0; i < BITS; i++) begin : g_bit
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni)      store[i] <= 1'b0;
                    else if (gate[i]) store[i] <= next[i];
                end
            end
        end else begin : g_latch
            for (genvar i = 0; i < BITS; i++) begin : g_bit
                always_latch begin
                    if (gate[i]) store[i] <= next[i];
                end
            end

            logic seen_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) seen_q <= 1'b0;
                else         seen_q <= 1'b1;
            end

            // R1
            clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (mode_i == MODE_CLEAR) |-> (q_o == '0));
            // R3
            demux_unsel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (mode_i == MODE_DEMUX) |-> ((q_o & ~sel_i) == '0));
            // R4
            write_sel_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (mode_i == MODE_WRITE) |-> (((q_o & sel_i) != '0) == d_i));
            // R5
            write_unsel_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && mode_i == MODE_WRITE && $past(mode_i) == MODE_WRITE && $stable(sel_i))
                |-> ((q_o & ~sel_i) == ($past(q_o) & ~sel_i)));
            // R6
            hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && mode_i == MODE_HOLD && $past(mode_i) == MODE_HOLD) |-> $stable(q_o));
            // R7
            capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (seen_q && mode_i == MODE_HOLD && $past(mode_i) == MODE_DEMUX
                 && $stable(sel_i) && $stable(d_i)) |-> $stable(q_o));
        end
    endgenerate

    assign q_o = store;
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
    import dal_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int NUM_BANKS  = 2,
    parameter bit REGISTERED = 1'b0,
    localparam int BITS      = 1 << ADDR_W
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      en_n_i,
    input  logic                      clr_n_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [NUM_BANKS-1:0]      d_i,
    output logic [NUM_BANKS*BITS-1:0] q_o
);
    mode_e           mode;
    logic [BITS-1:0] sel;

    dal_mode_dec u_mode (
        .en_n_i  (en_n_i),
        .clr_n_i (clr_n_i),
        .mode_o  (mode)
    );

    dal_addr_dec #(.ADDR_W(ADDR_W)) u_addr (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    generate
        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
            dal_bank #(.BITS(BITS), .REGISTERED(REGISTERED)) u_bank (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .mode_i (mode),
                .sel_i  (sel),
                .d_i    (d_i[k]),
                .q_o    (q_o[k*BITS +: BITS])
            );
        end

        if (!REGISTERED) begin : g_chk
            // R2
            demux_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!en_n_i && !clr_n_i) |-> (q_o[addr_i] == d_i[0]));
            // R8
            addr_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (!en_n_i && !clr_n_i && d_i[NUM_BANKS-1])
                |-> q_o[(NUM_BANKS-1)*BITS + int'(addr_i)]);
        end
    endgenerate
endmodule

// File: tb/dual_addr_latch_tb.sv
module dual_addr_latch_tb;
    localparam int NB = 2;
    localparam int AW = 2;
    localparam int NBIT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_n = 1'b1;
    logic clr_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] d = '0;
    logic [NB*NBIT-1:0] q;
    logic [NB*NBIT-1:0] exp_q = '0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_addr_latch u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_n_i(en_n), .clr_n_i(clr_n),
        .addr_i(addr), .d_i(d), .q_o(q)
    );

    task automatic model();
        for (int k = 0; k < NB; k++) begin
            for (int b = 0; b < NBIT; b++) begin
                bit s = (b == int'(addr));
                case ({en_n, clr_n})
                    2'b10: exp_q[k*NBIT+b] = 1'b0;
                    2'b00: exp_q[k*NBIT+b] = s ? d[k] : 1'b0;
                    2'b01: if (s) exp_q[k*NBIT+b] = d[k];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic drive(input logic [1:0] md, input logic [AW-1:0] a, input logic [NB-1:0] dv);
        @(negedge clk);
        en_n = md[1];
        clr_n = md[0];
        addr = a;
        d = dv;
        model();
        #2;
    endtask

    function automatic string tag_for(input logic [1:0] md, input bit s);
        case (md)
            2'b10:   return "R1";
            2'b00:   return s ? "R2" : "R3";
            2'b01:   return s ? "R4" : "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_all(input string over);
        for (int k = 0; k < NB; k++) begin
            for (int b = 0; b < NBIT; b++) begin
                string t = (over != "") ? over : tag_for({en_n, clr_n}, b == int'(addr));
                checks++;
                if (q[k*NBIT+b] !== exp_q[k*NBIT+b]) begin
                    errors++;
                    $display("FAIL %s bank %0d bit %0d: got %b expected %b", t, k, b,
                             q[k*NBIT+b], exp_q[k*NBIT+b]);
                end
            end
        end
    endtask

    task automatic check_word(input string t, input logic [NB*NBIT-1:0] e);
        checks++;
        if (q !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", t, q, e);
        end
    endtask

    initial begin
        // R1: clear mode gives the reset state
        drive(2'b10, 2'd0, 2'b00);
        check_word("R1", 8'h00);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int pm = 0; pm < 4; pm++) begin
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < 4; a++) begin
                    for (int dv = 0; dv < 4; dv++) begin
                        logic [NB-1:0] dd = NB'(dv);
                        // R6: address change only while holding
                        drive(2'b11, AW'(a), ~dd);
                        check_all("R6");
                        drive(2'(pm), AW'(a), ~dd);
                        check_all("");
                        // mode change and data change in the same step
                        drive(2'(m), AW'(a), dd);
                        check_all("");
                        // R9: toggle bank 0 data only
                        drive(2'(m), AW'(a), dd ^ 2'b01);
                        check_all("");
                        // R7: enter hold with data unchanged
                        drive(2'b11, AW'(a), dd ^ 2'b01);
                        check_all((m == 0 || m == 1) ? "R7" : "R6");
                        drive(2'b11, AW'(a), ~dd);
                        check_all("R6");
                    end
                end
            end
        end

        // R8: address index mapping, A0 least significant
        drive(2'b11, 2'b10, 2'b00);
        drive(2'b00, 2'b10, 2'b01);
        check_word("R8", 8'b0000_0100);
        // R9: bank 1 data reaches bank 1 only
        drive(2'b00, 2'b10, 2'b10);
        check_word("R9", 8'b0100_0000);
        drive(2'b11, 2'b01, 2'b10);
        drive(2'b00, 2'b01, 2'b11);
        check_word("R8", 8'b0010_0010);
        // R5: write keeps the previously stored bits
        drive(2'b11, 2'b01, 2'b11);
        drive(2'b11, 2'b11, 2'b00);
        drive(2'b01, 2'b11, 2'b11);
        check_word("R5", 8'b1010_1010);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule